// File: doc/BRIEF.md
# Bit-Serial Additive Scrambler

This block whitens a serial bit stream by adding (XOR) a pseudo-noise sequence to it, one bit per accepted cycle. The pseudo-noise source is a seven-stage linear feedback shift register with the recurrence x^7 + x^4 + 1. It is the one used by wireless LAN data scramblers. The register runs only when a data bit is accepted, so the sequence does not depend on the data. Idle cycles neither consume nor skip a sequence bit.

Each frame starts with a one-cycle frame-start pulse, which loads a seven-bit seed into the register. A receiver uses the same block with the same seed to undo the scrambling, because adding the same sequence twice gives back the original bits. An all-zero seed would freeze the register, so it is replaced by all ones. The raw sequence bit is also brought out beside the scrambled bit so that the generator can be checked on its own.

Top module: `scr_additive`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and sets all seven stages to 1. A stream sent after reset without a frame start is therefore scrambled exactly as if it had been seeded with all ones.
- R2: The stages are named s1..s7. On each step the sequence bit is p = s7 XOR s4. Then s1 takes p and each s(k+1) takes the old s(k).
- R3: With the all-ones seed, the first 16 sequence bits are 0000111011110010 (first bit on the left), and bit i equals bit i+127.
- R4: For each accepted bit, `out_data` is `in_data` XOR p and `pn_bit` is p.
- R5: `out_valid`, `out_data` and `pn_bit` are registered. They appear on the cycle after the one in which `in_valid` was high, and `out_valid` is low on the cycle after any cycle with `in_valid` low.
- R6: The register steps only on cycles with `in_valid` high. Idle gaps of any length leave the sequence unchanged.
- R7: When `sof` is high, `seed` is loaded with `seed[k]` going to stage s(k+1). If `in_valid` is high in the same cycle, that bit is scrambled with the first sequence bit produced from the new seed.
- R8: A `sof` pulse with `in_valid` low only loads the seed. The next accepted bit uses the first sequence bit of that seed.
- R9: A seed of all zeros is loaded as all ones.
- R10: Feeding the scrambled output back through the block with the same seed returns the original data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit is accepted this cycle |
| in_data | input | 1 | Input data bit |
| sof | input | 1 | Frame start: load the seed |
| seed | input | 7 | Seed value; bit k loads stage s(k+1) |
| out_valid | output | 1 | Output bit valid |
| out_data | output | 1 | Scrambled (or descrambled) bit |
| pn_bit | output | 1 | Sequence bit used for the output bit |

## Verification
The hardest case to reach from the ports is a frame start that lands in the same cycle as a data bit. In that case the seed must be used before it is stored. The stimulus drives frame starts both with and without a data bit, and places idle gaps right after reseeding. A zero seed is also applied in the middle of a stream. For descrambling, the outputs captured from the design during one frame are fed back in as the input of a second frame. A full 254-bit run is used to check that the sequence repeats after 127 bits.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int unsigned LFSR_W = 7;
    localparam int unsigned TAP_HI = 7;
    localparam int unsigned TAP_LO = 4;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef struct packed {
        lfsr_t state;
        logic  vld;
        logic  dat;
        logic  pn;
    } scr_reg_t;
endpackage

// File: rtl/scr_seed_fix.sv
module scr_seed_fix #(
    parameter int unsigned WIDTH = 7
) (
    input  logic [WIDTH-1:0] seed_in,
    output logic [WIDTH-1:0] seed_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    always_comb begin
        if (seed_in == '0) begin
            seed_out = ALL_ONES;
        end else begin
            seed_out = seed_in;
        end
    end
endmodule

// File: rtl/scr_lfsr_step.sv
module scr_lfsr_step #(
    parameter int unsigned WIDTH = 7,
    parameter int unsigned TAP_A = 7,
    parameter int unsigned TAP_B = 4
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt,
    output logic             fb
);
    localparam int unsigned IA = TAP_A - 1;
    localparam int unsigned IB = TAP_B - 1;

    assign fb     = cur[IA] ^ cur[IB];
    assign nxt[0] = fb;

    for (genvar k = 1; k < WIDTH; k++) begin : g_shift
        assign nxt[k] = cur[k-1];
    end
endmodule

// File: rtl/scr_additive.sv
module scr_additive
    import scr_pkg::*;
#(
    parameter int unsigned WIDTH = LFSR_W,
    parameter int unsigned TAP_A = TAP_HI,
    parameter int unsigned TAP_B = TAP_LO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_data,
    input  logic             sof,
    input  logic [WIDTH-1:0] seed,
    output logic             out_valid,
    output logic             out_data,
    output logic             pn_bit
);
    localparam logic [WIDTH-1:0] RESET_STATE = '1;

    typedef struct packed {
        logic [WIDTH-1:0] state;
        logic             vld;
        logic             dat;
        logic             pn;
    } reg_t;

    reg_t r_d, r_q;

    logic [WIDTH-1:0] seed_ok;
    logic [WIDTH-1:0] base;
    logic [WIDTH-1:0] stepped;
    logic             fb;
    logic [WIDTH-1:0] state_q;

    scr_seed_fix #(.WIDTH(WIDTH)) u_seed (
        .seed_in  (seed),
        .seed_out (seed_ok)
    );

    assign base = sof ? seed_ok : r_q.state;

    scr_lfsr_step #(.WIDTH(WIDTH), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_step (
        .cur (base),
        .nxt (stepped),
        .fb  (fb)
    );

    always_comb begin
        r_d       = r_q;
        r_d.state = base;
        r_d.vld   = in_valid;
        if (in_valid) begin
            r_d.state = stepped;
            r_d.dat   = in_data ^ fb;
            r_d.pn    = fb;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= RESET_STATE;
            r_q.vld   <= 1'b0;
            r_q.dat   <= 1'b0;
            r_q.pn    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q   = r_q.state;
    assign out_valid = r_q.vld;
    assign out_data  = r_q.dat;
    assign pn_bit    = r_q.pn;
endmodule

// File: rtl/scr_additive_chk.sv
module scr_additive_chk #(
    parameter int unsigned WIDTH = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_data,
    input logic             sof,
    input logic             out_valid,
    input logic             out_data,
    input logic             pn_bit,
    input logic [WIDTH-1:0] state
);
    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !sof) |=> $stable(state));

    assert_never_zero_R9: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    assert_additive_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_data == ($past(in_data) ^ pn_bit)));
endmodule

bind scr_additive scr_additive_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .sof       (sof),
    .out_valid (out_valid),
    .out_data  (out_data),
    .pn_bit    (pn_bit),
    .state     (state_q)
);

// File: tb/scr_additive_bench.sv
module scr_additive_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_data = 1'b0;
    logic       sof = 1'b0;
    logic [6:0] seed = 7'h00;
    logic       out_valid;
    logic       out_data;
    logic       pn_bit;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic done = 1'b0;

    typedef struct {
        int    stamp;
        logic  vld;
        logic  dat;
        logic  pn;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    logic cap_dat[$];
    logic cap_pn[$];
    logic [6:0] model;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scr_additive u_scr_additive (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .sof       (sof),
        .seed      (seed),
        .out_valid (out_valid),
        .out_data  (out_data),
        .pn_bit    (pn_bit)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic d, input logic s, input logic [6:0] sd,
                         input string tag);
        exp_t e;
        logic p;
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        sof      = s;
        seed     = sd;
        if (s) model = (sd == 7'h00) ? 7'h7F : sd;
        e.stamp = cyc;
        e.vld   = v;
        e.dat   = 1'b0;
        e.pn    = 1'b0;
        e.tag   = tag;
        if (v) begin
            p     = model[6] ^ model[3];
            model = {model[5:0], p};
            e.dat = d ^ p;
            e.pn  = p;
        end
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0 && exp_q[0].stamp < cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            check(out_valid == e.vld, {e.tag, " valid"}, out_valid, e.vld);
            if (e.vld) begin
                check(out_data == e.dat, {e.tag, " data"}, out_data, e.dat);
                check(pn_bit == e.pn, {e.tag, " pn"}, pn_bit, e.pn);
                cap_dat.push_back(out_data);
                cap_pn.push_back(pn_bit);
            end
        end
    end

    task automatic settle();
        drive(1'b0, 1'b0, 1'b0, 7'h00, "R5");
        drive(1'b0, 1'b0, 1'b0, 7'h00, "R5");
        @(negedge clk);
    endtask

    initial begin
        logic orig[$];
        logic [15:0] lit;
        model = 7'h7F;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);

        // R1: no sof after reset, zero data exposes the all-ones sequence (R2, R3)
        cap_dat.delete(); cap_pn.delete();
        for (int i = 0; i < 16; i++) drive(1'b1, 1'b0, 1'b0, 7'h00, "R1");
        settle();
        lit = 16'b0000111011110010;
        for (int i = 0; i < 16; i++)
            check(cap_pn[i] == lit[15-i], "R3 literal", cap_pn[i], lit[15-i]);

        // R3 period, R7 sof with valid in same cycle
        cap_dat.delete(); cap_pn.delete();
        for (int i = 0; i < 254; i++)
            drive(1'b1, i[0] ^ i[3], i == 0, 7'h7F, "R7");
        settle();
        for (int i = 0; i < 127; i++)
            check(cap_pn[i] == cap_pn[i+127], "R3 period", cap_pn[i+127], cap_pn[i]);
        check(cap_pn[0] == 1'b0 && cap_pn[4] == 1'b1, "R3 start", cap_pn[4], 1);

        // R6 gaps, R8 sof alone, odd seed for R2 bit order
        drive(1'b0, 1'b0, 1'b1, 7'h35, "R8");
        for (int i = 0; i < 40; i++) begin
            drive(1'b1, i[1], 1'b0, 7'h00, "R8");
            if (i % 5 == 2) begin
                for (int g = 0; g < (i % 7) + 1; g++) drive(1'b0, 1'b1, 1'b0, 7'h00, "R6");
            end
        end

        // R9 zero seed mid-stream, both with and without valid
        drive(1'b1, 1'b1, 1'b1, 7'h00, "R9");
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 1'b0, 7'h00, "R9");
        drive(1'b0, 1'b0, 1'b1, 7'h00, "R9");
        for (int i = 0; i < 20; i++) drive(1'b1, i[2], 1'b0, 7'h00, "R9");
        settle();

        // R10 descramble round trip with seed 0x4B
        cap_dat.delete(); cap_pn.delete(); orig.delete();
        for (int i = 0; i < 60; i++) begin
            orig.push_back(i[0] ^ i[2] ^ i[4]);
            drive(1'b1, orig[i], i == 0, 7'h4B, "R4");
        end
        settle();
        begin
            logic scr[$];
            scr = cap_dat;
            cap_dat.delete(); cap_pn.delete();
            for (int i = 0; i < 60; i++) drive(1'b1, scr[i], i == 0, 7'h4B, "R10");
            settle();
            for (int i = 0; i < 60; i++)
                check(cap_dat[i] == orig[i], "R10 recover", cap_dat[i], orig[i]);
        end

        // R1 again: reset mid-run returns to all-ones state
        rst = 1'b1;
        exp_q.delete();
        @(negedge clk);
        rst = 1'b0;
        model = 7'h7F;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        for (int i = 0; i < 10; i++) drive(1'b1, 1'b1, 1'b0, 7'h00, "R1");
        settle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule